// File: doc/BRIEF.md
# Cable Port Power and Suspend Controller

This block decides, for each cable port of a serial-bus physical layer, whether the port's transceiver (transmitter and receiver) and its local twisted-pair bias generator are switched on. The inputs are all digital:

- the node's global power-down and logic reset;
- per-port cable-connected status;
- per-port incoming-bias detection;
- per-port requests from the arbitration logic to silence a transceiver;
- per-port disable commands from the link layer;
- suspend and resume strobes from the arbitration logic.

Each port holds a registered state of disabled, active or suspended. A suspended port is quiet and keeps only its detection monitors. Any connection change or new incoming bias on a suspended port raises a one-cycle wake request.

At node level the block produces two flags. The first is a cable-idle flag, high when no port has a cable; it is not filtered and keeps working through reset and power-down. The second is a core power-down flag, raised when every port is suspended, which leaves only the bias detectors running. All enables and flags are registered, so a clean edge reaches the analog side.

Top module: `cport_power_ctl`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), every port is disabled. `xcvr_en_o`, `bias_en_o`, `resume_req_o` and `core_pd_o` are 0, and `cdmon_en_o` is all ones.
- R2: When `pwr_down_i` is high at a clock edge, every port is disabled after that edge, with transceiver and bias enables at 0. This holds whatever the strobes and commands are.
- R3: A port's `xcvr_en_o` bit is 1 after an edge only if the port is active, its cable is connected and its `arb_off_i` bit is 0. A disconnected cable or a set `arb_off_i` bit clears it at the next edge.
- R4: A port's `bias_en_o` bit is 1 after an edge exactly when `pwr_down_i` is low, its `link_dis_i` bit is 0 and the port is not suspended. Cable presence does not matter.
- R5: The port state follows these rules:
  - A set `link_dis_i` bit forces the port to disabled.
  - A disabled port with a connected cable becomes active.
  - An active port whose cable drops becomes disabled.
- R6: A `susp_req_i` strobe on an active, still-connected port moves it to suspended, where both enables are 0. On a disabled port the strobe is ignored. If the cable drops in the same cycle, the port goes disabled instead.
- R7: A `resume_i` strobe on a suspended port moves it to active if its cable is connected, else to disabled.
- R8: While a port is suspended, a change of its `conn_i` bit or a 0-to-1 step of its `bias_in_i` bit raises its `resume_req_o` bit for exactly the following cycle. A port that is not suspended never raises it.
- R9: Each `cdmon_en_o` bit is the complement of the matching `bias_en_o` bit. Connect-detect runs only while local bias is off.
- R10: `cable_idle_o` equals, one edge later, the NOR of all `conn_i` bits, with no filtering. It keeps tracking through reset and power-down.
- R11: `core_pd_o` is 1 after an edge exactly when every port is suspended after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous logic reset, active low |
| pwr_down_i | input | 1 | Global power-down |
| conn_i | input | NPORTS | Cable connected, per port |
| bias_in_i | input | NPORTS | Incoming bias detected, per port |
| arb_off_i | input | NPORTS | Arbitration asks transceiver off, per port |
| link_dis_i | input | NPORTS | Link layer commands port disabled |
| susp_req_i | input | NPORTS | Suspend strobe, per port |
| resume_i | input | NPORTS | Resume strobe, per port |
| xcvr_en_o | output | NPORTS | Transceiver enable |
| bias_en_o | output | NPORTS | Local bias generator enable |
| cdmon_en_o | output | NPORTS | Connect-detect monitor enable |
| resume_req_o | output | NPORTS | One-cycle wake request from a suspended port |
| cable_idle_o | output | 1 | No port has a cable |
| core_pd_o | output | 1 | All ports suspended; core may power down |

## Verification
Two pairs of port functions can coincide in one cycle.

- **Suspend strobe with a cable loss.** The bench strobes suspend on an active port in the same cycle its cable drops. The port must end disabled with its bias still on, not suspended.
- **Resume strobe with a cable change.** The bench strobes resume on a suspended port in the same cycle its cable drops. The wake request must still pulse, and the port must leave suspend for disabled rather than active.

A scoreboard model of the requirements judges the full output bundle one edge after each stimulus.

// File: rtl/cport_pkg.sv
package cport_pkg;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_ACT  = 2'd1,
    PS_SUSP = 2'd2
  } pstate_t;

  // Next port state; power-down beats link disable beats strobes.
  function automatic pstate_t next_pstate(
    input pstate_t cur,
    input logic    pd,
    input logic    ldis,
    input logic    conn,
    input logic    sreq,
    input logic    rsm
  );
    pstate_t n;
    n = cur;
    if (pd || ldis) begin
      n = PS_OFF;
    end else begin
      case (cur)
        PS_OFF:  n = conn ? PS_ACT : PS_OFF;
        PS_ACT:  n = !conn ? PS_OFF : (sreq ? PS_SUSP : PS_ACT);
        PS_SUSP: n = rsm ? (conn ? PS_ACT : PS_OFF) : PS_SUSP;
        default: n = PS_OFF;
      endcase
    end
    return n;
  endfunction

  // Transceiver may run only when the port is active and arbitration allows it.
  function automatic logic xcvr_ok(input pstate_t nxt, input logic arb);
    return (nxt == PS_ACT) && !arb;
  endfunction

  // Bias generator runs unless powered down, link-disabled or suspended.
  function automatic logic bias_ok(input pstate_t nxt, input logic pd, input logic ldis);
    return !pd && !ldis && (nxt != PS_SUSP);
  endfunction

  // Wake event seen by a suspended port.
  function automatic logic wake_event(
    input pstate_t cur,
    input logic    conn,
    input logic    conn_q,
    input logic    bin,
    input logic    bin_q
  );
    return (cur == PS_SUSP) && ((conn != conn_q) || (bin && !bin_q));
  endfunction

endpackage

// File: rtl/cport_lane.sv
module cport_lane
  import cport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down_i,
  input  logic conn_i,
  input  logic bias_in_i,
  input  logic arb_off_i,
  input  logic link_dis_i,
  input  logic susp_req_i,
  input  logic resume_i,
  output logic xcvr_en_o,
  output logic bias_en_o,
  output logic cdmon_en_o,
  output logic resume_req_o,
  output logic susp_nxt_o,
  output logic susp_now_o
);

  pstate_t st_q;
  pstate_t st_d;
  logic    conn_q;
  logic    bin_q;
  logic    wake_evt;
  logic    bias_d;
  logic    xcvr_d;

  assign st_d       = next_pstate(st_q, pwr_down_i, link_dis_i, conn_i, susp_req_i, resume_i);
  assign wake_evt   = wake_event(st_q, conn_i, conn_q, bias_in_i, bin_q);
  assign bias_d     = bias_ok(st_d, pwr_down_i, link_dis_i);
  assign xcvr_d     = xcvr_ok(st_d, arb_off_i);
  assign susp_nxt_o = (st_d == PS_SUSP);
  assign susp_now_o = (st_q == PS_SUSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= PS_OFF;
      conn_q       <= 1'b0;
      bin_q        <= 1'b0;
      xcvr_en_o    <= 1'b0;
      bias_en_o    <= 1'b0;
      cdmon_en_o   <= 1'b1;
      resume_req_o <= 1'b0;
    end else begin
      st_q         <= st_d;
      conn_q       <= conn_i;
      bin_q        <= bias_in_i;
      xcvr_en_o    <= xcvr_d;
      bias_en_o    <= bias_d;
      cdmon_en_o   <= ~bias_d;
      resume_req_o <= wake_evt;
    end
  end

  // R2
  pd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_i |=> (!xcvr_en_o && !bias_en_o && st_q == PS_OFF));

  // R3
  xcvr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conn_i || arb_off_i) |=> !xcvr_en_o);

  // R4
  link_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_dis_i |=> !bias_en_o);

  // R6
  susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_SUSP) |-> (!xcvr_en_o && !bias_en_o));

  // R8
  wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req_o |-> ($past(st_q) == PS_SUSP));

endmodule

// File: rtl/cport_node_flags.sv
module cport_node_flags #(
  parameter int NPORTS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] conn_i,
  input  logic [NPORTS-1:0] susp_nxt_i,
  input  logic [NPORTS-1:0] susp_now_i,
  output logic              cable_idle_o,
  output logic              core_pd_o
);

  logic no_cable;
  logic all_susp;

  assign no_cable = ~|conn_i;
  assign all_susp = &susp_nxt_i;

  // Cable-idle keeps tracking through reset: deliberately no reset term.
  always_ff @(posedge clk) begin
    cable_idle_o <= no_cable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_pd_o <= 1'b0;
    else        core_pd_o <= all_susp;
  end

  // R10
  idle_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cable_idle_o == $past(~|conn_i));

  // R11
  core_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_pd_o |-> (&susp_now_i));

  // R11
  core_pd_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&susp_now_i) |-> core_pd_o);

endmodule

// File: rtl/cport_power_ctl.sv
module cport_power_ctl #(
  parameter int NPORTS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down_i,
  input  logic [NPORTS-1:0] conn_i,
  input  logic [NPORTS-1:0] bias_in_i,
  input  logic [NPORTS-1:0] arb_off_i,
  input  logic [NPORTS-1:0] link_dis_i,
  input  logic [NPORTS-1:0] susp_req_i,
  input  logic [NPORTS-1:0] resume_i,
  output logic [NPORTS-1:0] xcvr_en_o,
  output logic [NPORTS-1:0] bias_en_o,
  output logic [NPORTS-1:0] cdmon_en_o,
  output logic [NPORTS-1:0] resume_req_o,
  output logic              cable_idle_o,
  output logic              core_pd_o
);

  logic [NPORTS-1:0] susp_nxt;
  logic [NPORTS-1:0] susp_now;

  for (genvar p = 0; p < NPORTS; p++) begin : g_lane
    cport_lane u_lane (
      .clk          (clk),
      .rst_n        (rst_n),
      .pwr_down_i   (pwr_down_i),
      .conn_i       (conn_i[p]),
      .bias_in_i    (bias_in_i[p]),
      .arb_off_i    (arb_off_i[p]),
      .link_dis_i   (link_dis_i[p]),
      .susp_req_i   (susp_req_i[p]),
      .resume_i     (resume_i[p]),
      .xcvr_en_o    (xcvr_en_o[p]),
      .bias_en_o    (bias_en_o[p]),
      .cdmon_en_o   (cdmon_en_o[p]),
      .resume_req_o (resume_req_o[p]),
      .susp_nxt_o   (susp_nxt[p]),
      .susp_now_o   (susp_now[p])
    );
  end

  cport_node_flags #(.NPORTS(NPORTS)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .conn_i       (conn_i),
    .susp_nxt_i   (susp_nxt),
    .susp_now_i   (susp_now),
    .cable_idle_o (cable_idle_o),
    .core_pd_o    (core_pd_o)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (xcvr_en_o == '0 && resume_req_o == '0 && !core_pd_o));

endmodule

// File: tb/sim_cport_power_ctl.sv
`timescale 1ns/1ps
module sim_cport_power_ctl;

  localparam int N = 3;
  localparam int M_OFF = 0, M_ACT = 1, M_SUS = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pd = 1'b0;
  logic [N-1:0] conn = '0, bin = '0, arb = '0, ldis = '0, sreq = '0, rsm = '0;
  logic [N-1:0] xcvr, bias, cdm, rreq;
  logic         idle, cpd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int   mst [N];
  logic mcq [N];
  logic mbq [N];

  logic [13:0] qv[$];
  string       qt[$];

  always #5 clk = ~clk;

  cport_power_ctl #(.NPORTS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_down_i(pd), .conn_i(conn), .bias_in_i(bin),
    .arb_off_i(arb), .link_dis_i(ldis), .susp_req_i(sreq), .resume_i(rsm),
    .xcvr_en_o(xcvr), .bias_en_o(bias), .cdmon_en_o(cdm), .resume_req_o(rreq),
    .cable_idle_o(idle), .core_pd_o(cpd)
  );

  // Driver: applies one cycle of stimulus and queues the expected outputs.
  task automatic step(input logic r, input logic p, input logic [N-1:0] c,
                      input logic [N-1:0] b, input logic [N-1:0] a,
                      input logic [N-1:0] l, input logic [N-1:0] s,
                      input logic [N-1:0] z, input string tag);
    logic [N-1:0] ex, eb, ew;
    int           nsus;
    @(negedge clk);
    rst_n = r; pd = p; conn = c; bin = b; arb = a; ldis = l; sreq = s; rsm = z;
    ex = '0; eb = '0; ew = '0; nsus = 0;
    for (int i = 0; i < N; i++) begin
      int nx;
      if (!r) begin
        mst[i] = M_OFF; mcq[i] = 1'b0; mbq[i] = 1'b0;
        continue;
      end
      ew[i] = (mst[i] == M_SUS) && ((c[i] !== mcq[i]) || (b[i] && !mbq[i]));
      nx = mst[i];
      if (p || l[i])                nx = M_OFF;
      else if (mst[i] == M_OFF)     nx = c[i] ? M_ACT : M_OFF;
      else if (mst[i] == M_ACT)     nx = !c[i] ? M_OFF : (s[i] ? M_SUS : M_ACT);
      else if (z[i])                nx = c[i] ? M_ACT : M_OFF;
      mst[i] = nx;
      mcq[i] = c[i];
      mbq[i] = b[i];
      ex[i]  = (nx == M_ACT) && !a[i];
      eb[i]  = !p && !l[i] && (nx != M_SUS);
      if (nx == M_SUS) nsus++;
    end
    qv.push_back({ex, eb, ~eb, ew, (c == '0), (r && nsus == N)});
    qt.push_back(tag);
  endtask

  // Monitor: compares the bundle just after each active edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (qv.size() > 0) begin
        logic [13:0] e, g;
        string       t;
        e = qv.pop_front();
        t = qt.pop_front();
        g = {xcvr, bias, cdm, rreq, idle, cpd};
        checks++;
        if (g !== e) begin
          failures++;
          $display("FAIL %s got=%b exp=%b (xcvr,bias,cdm,rreq,idle,cpd)", t, g, e);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mst[i] = M_OFF; mcq[i] = 1'b0; mbq[i] = 1'b0; end
    //   rst  pd  conn    bin     arb     ldis    sreq    rsm
    step(0, 0, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R1 reset, no cable (R10)");
    step(0, 0, 3'b101, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R1 R10 idle tracks in reset");
    step(1, 0, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R4 bias on without cable");
    step(1, 0, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R5 R3 ports go active");
    step(1, 0, 3'b111, 3'b000, 3'b010, 3'b000, 3'b000, 3'b000, "R3 arbitration silences port1");
    step(1, 0, 3'b111, 3'b000, 3'b000, 3'b100, 3'b000, 3'b000, "R4 R5 link disables port2");
    step(1, 0, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R5 port2 back active");
    step(1, 0, 3'b111, 3'b000, 3'b000, 3'b000, 3'b001, 3'b000, "R6 R9 port0 suspends");
    step(1, 0, 3'b011, 3'b000, 3'b000, 3'b000, 3'b100, 3'b000, "R6 suspend with cable loss");
    step(1, 0, 3'b011, 3'b001, 3'b000, 3'b000, 3'b000, 3'b000, "R8 incoming bias wakes port0");
    step(1, 0, 3'b011, 3'b001, 3'b000, 3'b000, 3'b000, 3'b000, "R8 wake is one cycle");
    step(1, 0, 3'b011, 3'b000, 3'b000, 3'b000, 3'b000, 3'b001, "R7 resume port0 connected");
    step(1, 0, 3'b111, 3'b000, 3'b000, 3'b000, 3'b001, 3'b000, "R6 port0 suspends again");
    step(1, 0, 3'b111, 3'b000, 3'b000, 3'b000, 3'b110, 3'b000, "R11 all suspended");
    step(1, 0, 3'b101, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R8 cable loss wakes port1");
    step(1, 0, 3'b101, 3'b000, 3'b000, 3'b000, 3'b000, 3'b010, "R7 R11 resume unconnected");
    step(1, 0, 3'b100, 3'b000, 3'b000, 3'b000, 3'b000, 3'b001, "R7 R8 resume with cable loss");
    step(1, 0, 3'b100, 3'b000, 3'b000, 3'b000, 3'b010, 3'b000, "R6 strobe on disabled ignored");
    step(1, 1, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R2 R10 power-down, idle");
    step(1, 1, 3'b010, 3'b000, 3'b000, 3'b000, 3'b001, 3'b000, "R2 R10 power-down, cable");
    step(1, 0, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R5 leave power-down");
    step(1, 0, 3'b111, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000, "R8 no wake when active");
    step(1, 0, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, "R3 steady active");
    while (qv.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule